// File: doc/BRIEF.md
# Pulse Interval Difference Histogrammer

The block takes the arrival times of the pulses in one received frame. They are held in an external memory as unsigned fixed-point integers. It searches the frame for repeating intervals. Work goes level by level. At level k, every pulse is paired with the pulse k positions later, and the time between them is counted into a per-level histogram. The bin of a count is the interval shifted right by a programmable exponent. When a level's pairs are all counted, its histogram is added into a cumulative histogram that is kept across levels. The cumulative bins are then compared, from the shortest interval upward, against a threshold table that is indexed by bin.

Each level ends with one result beat on a valid/ready output. The beat carries the level number, a found flag, and the lowest bin that crossed its threshold. The block stalls until the beat is accepted, so the consumer decides when the next level starts. A stop pulse ends the run at any point. Both external memories (arrival times and thresholds) are read through address outputs and return data one clock after the address.

Top module: `ivh_top`

## Requirements
- R1: After reset, `busy`, `done` and `res_valid` are all 0.
- R2: At level k, for each i from 0 while i+k < `pulse_cnt`, the interval is TOA[i+k]-TOA[i] and its bin is the interval shifted right by `bin_shift`. A pair whose later time is smaller, or whose bin is not below BINS, is not counted.
- R3: A `start` pulse in idle clears the cumulative histogram. Each level's histogram starts empty, and the cumulative histogram carries its totals from one level to the next within a run.
- R4: After a level is accumulated, `res_found`=1 and `res_bin` is the lowest bin b for which cumulative[b] > threshold[b]. Threshold[b] is the word the threshold memory returns for address b.
- R5: When no bin exceeds its threshold, `res_found`=0 and `res_bin`=0, and the next level follows.
- R6: Each run gives exactly one result beat per level. The levels come in order from 1 to `max_level`, and `res_level` carries the level number.
- R7: `res_valid` and the values of `res_found`, `res_bin` and `res_level` hold until `res_ready` is high at a clock edge. No further level is processed while the block waits.
- R8: `stop` while busy ends the run at the next edge: `done` pulses, `busy` falls, and no more beats appear.
- R9: `done` pulses for one cycle after the last beat is accepted. When `pulse_cnt` < 2 or `max_level` = 0, `done` pulses right after start and no beat is issued.
- R10: Every bin count saturates at 2^CNT_W-1, both in the per-level count and in the cumulative sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run, sampled in idle |
| stop | input | 1 | Abort the run |
| pulse_cnt | input | N_W | Number of valid arrival times, at most N_MAX |
| max_level | input | N_W | Last level to process |
| bin_shift | input | SH_W | Bin-width exponent |
| toa_addr | output | IDX_W | Arrival-time memory address |
| toa_data | input | TOA_W | Arrival time, one cycle after the address |
| thr_addr | output | BIN_W | Threshold memory address |
| thr_data | input | CNT_W | Threshold, one cycle after the address |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Result beat accepted |
| res_found | output | 1 | A bin crossed its threshold |
| res_bin | output | BIN_W | Lowest crossing bin |
| res_level | output | N_W | Level of this beat |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The main function is driven with several kinds of frames:
- a single strictly periodic train, which must give the same found bin at every level;
- two interleaved step patterns, where cumulative totals build up across levels before they cross;
- trains with coarse bin exponents, which merge intervals into the low bins;
- trains with intervals too wide for any bin, which must report nothing.

Thresholds that rise with the bin index separate a lowest-bin search from a highest-count search. A frame whose times are all equal separates saturating sums from wrapping sums. Running a sparse frame right after it shows that start clears the cumulative totals. Stalling the result stream, and stopping both during counting and at a pending beat, covers the level gating.

// File: rtl/ivh_pkg.sv
package ivh_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RDA, S_RDB, S_INC, S_ACC, S_SCA, S_SCB, S_RES, S_DONE
  } ivh_state_e;
endpackage

// File: rtl/ivh_binmap.sv
module ivh_binmap #(
  parameter int TOA_W = 32,
  parameter int BINS  = 256,
  parameter int SH_W  = 5,
  localparam int BIN_W = $clog2(BINS)
) (
  input  logic [TOA_W-1:0] early,
  input  logic [TOA_W-1:0] late,
  input  logic [SH_W-1:0]  shift,
  output logic             hit,
  output logic [BIN_W-1:0] bin
);
  logic [TOA_W-1:0] gap;
  logic [TOA_W-1:0] scaled;

  always_comb begin
    gap    = late - early;
    scaled = gap >> shift;
    hit    = (late >= early) && (scaled < TOA_W'(BINS));
    bin    = scaled[BIN_W-1:0];
  end
endmodule

// File: rtl/ivh_lvl_hist.sv
module ivh_lvl_hist #(
  parameter int BINS  = 256,
  parameter int CNT_W = 16,
  localparam int BIN_W = $clog2(BINS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        inc,
  input  logic [BIN_W-1:0]            addr,
  output logic [BINS-1:0][CNT_W-1:0]  cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && cnt[addr] != TOP) begin
      cnt[addr] <= cnt[addr] + 1'b1;
    end
  end

  // R10: a full bin stays full when it is counted again
  a_r10_lvl_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt[addr] == TOP) |=> cnt[$past(addr)] == TOP);
endmodule

// File: rtl/ivh_cum_hist.sv
module ivh_cum_hist #(
  parameter int BINS  = 256,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        add,
  input  logic [BINS-1:0][CNT_W-1:0]  part,
  output logic [BINS-1:0][CNT_W-1:0]  total
);
  for (genvar b = 0; b < BINS; b++) begin : g_bin
    logic [CNT_W:0] sum;
    assign sum = {1'b0, total[b]} + {1'b0, part[b]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     total[b] <= '0;
      else if (clr)   total[b] <= '0;
      else if (add)   total[b] <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  // R10: the cumulative sum never wraps below its previous value
  a_r10_cum_mono: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr) |=> total[0] >= $past(total[0]));
endmodule

// File: rtl/ivh_top.sv
module ivh_top #(
  parameter int TOA_W = 32,
  parameter int N_MAX = 256,
  parameter int BINS  = 256,
  parameter int CNT_W = 16,
  parameter int SH_W  = 5,
  localparam int N_W   = $clog2(N_MAX + 1),
  localparam int IDX_W = $clog2(N_MAX),
  localparam int BIN_W = $clog2(BINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [N_W-1:0]   pulse_cnt,
  input  logic [N_W-1:0]   max_level,
  input  logic [SH_W-1:0]  bin_shift,
  output logic [IDX_W-1:0] toa_addr,
  input  logic [TOA_W-1:0] toa_data,
  output logic [BIN_W-1:0] thr_addr,
  input  logic [CNT_W-1:0] thr_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_found,
  output logic [BIN_W-1:0] res_bin,
  output logic [N_W-1:0]   res_level,
  output logic             busy,
  output logic             done
);
  import ivh_pkg::*;

  ivh_state_e st;
  logic [N_W-1:0]   n_q, kmax_q, k_q, i_q;
  logic [SH_W-1:0]  sh_q;
  logic [TOA_W-1:0] a_q;
  logic [BIN_W-1:0] j_q, bin_q;
  logic             found_q;
  logic [BINS-1:0][CNT_W-1:0] lvl_cnt, cum_cnt;
  logic             clr_cum, clr_lvl, inc_en, acc_en, hit;
  logic [BIN_W-1:0] map_bin;
  logic [N_W:0]     pair_next, lvl_next;
  logic             advance;

  assign pair_next = {1'b0, i_q} + {1'b0, k_q} + 1'b1;
  assign lvl_next  = {1'b0, k_q} + 1'b1;
  assign advance   = (st == S_RES) && res_ready && !stop && (k_q != kmax_q);
  assign clr_cum   = (st == S_IDLE) && start;
  assign clr_lvl   = clr_cum || advance;
  assign inc_en    = (st == S_INC) && hit;
  assign acc_en    = (st == S_ACC);

  always_comb begin
    if (st == S_RDB) toa_addr = IDX_W'(i_q + k_q);
    else             toa_addr = IDX_W'(i_q);
  end
  assign thr_addr = j_q;

  ivh_binmap #(.TOA_W(TOA_W), .BINS(BINS), .SH_W(SH_W)) u_map (
    .early(a_q), .late(toa_data), .shift(sh_q), .hit(hit), .bin(map_bin)
  );

  ivh_lvl_hist #(.BINS(BINS), .CNT_W(CNT_W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .clr(clr_lvl), .inc(inc_en),
    .addr(map_bin), .cnt(lvl_cnt)
  );

  ivh_cum_hist #(.BINS(BINS), .CNT_W(CNT_W)) u_cum (
    .clk(clk), .rst_n(rst_n), .clr(clr_cum), .add(acc_en),
    .part(lvl_cnt), .total(cum_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      n_q <= '0; kmax_q <= '0; k_q <= '0; i_q <= '0;
      sh_q <= '0; a_q <= '0; j_q <= '0; bin_q <= '0; found_q <= 1'b0;
    end else if (stop && st != S_IDLE && st != S_DONE) begin
      st <= S_DONE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          n_q    <= pulse_cnt;
          kmax_q <= max_level;
          sh_q   <= bin_shift;
          k_q    <= N_W'(1);
          i_q    <= '0;
          if (pulse_cnt < N_W'(2) || max_level == '0) st <= S_DONE;
          else                                        st <= S_RDA;
        end
        S_RDA: st <= S_RDB;
        S_RDB: begin
          a_q <= toa_data;
          st  <= S_INC;
        end
        S_INC: begin
          if (pair_next < {1'b0, n_q}) begin
            i_q <= i_q + 1'b1;
            st  <= S_RDA;
          end else begin
            st <= S_ACC;
          end
        end
        S_ACC: begin
          j_q <= '0;
          st  <= S_SCA;
        end
        S_SCA: st <= S_SCB;
        S_SCB: begin
          if (cum_cnt[j_q] > thr_data) begin
            found_q <= 1'b1;
            bin_q   <= j_q;
            st      <= S_RES;
          end else if (j_q == BIN_W'(BINS - 1)) begin
            found_q <= 1'b0;
            bin_q   <= '0;
            st      <= S_RES;
          end else begin
            j_q <= j_q + 1'b1;
            st  <= S_SCA;
          end
        end
        S_RES: if (res_ready) begin
          if (k_q == kmax_q) begin
            st <= S_DONE;
          end else begin
            k_q <= k_q + 1'b1;
            i_q <= '0;
            st  <= (lvl_next < {1'b0, n_q}) ? S_RDA : S_ACC;
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign res_valid = (st == S_RES);
  assign res_found = found_q;
  assign res_bin   = bin_q;
  assign res_level = k_q;
  assign busy      = (st != S_IDLE) && (st != S_DONE);
  assign done      = (st == S_DONE);

  // R7: a pending beat and its payload hold while it is not accepted
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !stop) |=>
      (res_valid && $stable(res_found) && $stable(res_bin) && $stable(res_level)));

  // R8: stop during a run ends it at the next edge
  a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop) |=> (done && !res_valid));

  // R9: done lasts a single cycle and leaves the block idle
  a_r9_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R6: an accepted beat that is not the last advances the level by one
  a_r6_next_level: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !stop && !done && res_level != kmax_q) |=>
      (res_level == $past(res_level) + 1'b1));
endmodule

// File: tb/sim_ivh_top.sv
module sim_ivh_top;
  localparam int TOA_W = 32;
  localparam int N_MAX = 16;
  localparam int BINS  = 16;
  localparam int CNT_W = 4;
  localparam int SH_W  = 5;
  localparam int N_W   = $clog2(N_MAX + 1);
  localparam int IDX_W = $clog2(N_MAX);
  localparam int BIN_W = $clog2(BINS);
  localparam int CMAX  = (1 << CNT_W) - 1;

  // n, max level, shift, step1, step2, thr base, thr slope
  localparam int NV = 7;
  localparam int VEC [NV][7] = '{
    '{ 8, 3, 0,  5, 0,  1, 0},
    '{12, 4, 2,  7, 3,  3, 1},
    '{16, 5, 3,  9, 4, 12, 2},
    '{10, 6, 1,  3, 2,  2, 0},
    '{16, 3, 6, 10, 0,  0, 0},
    '{ 6, 8, 0, 20, 0,  0, 0},
    '{14, 5, 1,  6, 3,  1, 1}
  };

  logic clk = 0, rst_n = 0, start = 0, stop = 0, res_ready = 0;
  logic [N_W-1:0] pulse_cnt = '0, max_level = '0;
  logic [SH_W-1:0] bin_shift = '0;
  logic [IDX_W-1:0] toa_addr;
  logic [TOA_W-1:0] toa_data;
  logic [BIN_W-1:0] thr_addr, res_bin;
  logic [CNT_W-1:0] thr_data;
  logic res_valid, res_found, busy, done;
  logic [N_W-1:0] res_level;

  logic [TOA_W-1:0] mem [N_MAX];
  logic [CNT_W-1:0] thrm [BINS];
  int checks = 0, fails = 0;
  bit finished = 0;
  int ef [33];
  int eb [33];

  always #4 clk = ~clk;
  always_ff @(posedge clk) begin
    toa_data <= mem[toa_addr];
    thr_data <= thrm[thr_addr];
  end

  ivh_top #(.TOA_W(TOA_W), .N_MAX(N_MAX), .BINS(BINS), .CNT_W(CNT_W), .SH_W(SH_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .pulse_cnt(pulse_cnt),
    .max_level(max_level), .bin_shift(bin_shift), .toa_addr(toa_addr),
    .toa_data(toa_data), .thr_addr(thr_addr), .thr_data(thr_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_found(res_found),
    .res_bin(res_bin), .res_level(res_level), .busy(busy), .done(done)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic load(int s1, int s2, int base, int slope);
    for (int i = 0; i < N_MAX; i++) mem[i] = TOA_W'(i * s1 + (i % 3) * s2);
    for (int b = 0; b < BINS; b++) begin
      int t = base + slope * b;
      thrm[b] = CNT_W'((t > CMAX) ? CMAX : t);
    end
  endtask

  task automatic model(int n, int maxl, int sh);
    int cum [BINS];
    int lv [BINS];
    for (int b = 0; b < BINS; b++) cum[b] = 0;
    for (int k = 1; k <= maxl; k++) begin
      for (int b = 0; b < BINS; b++) lv[b] = 0;
      for (int i = 0; i + k < n; i++) begin
        if (mem[i+k] >= mem[i]) begin
          longint d = longint'(mem[i+k] - mem[i]) >> sh;
          if (d < BINS && lv[int'(d)] < CMAX) lv[int'(d)]++;
        end
      end
      ef[k] = 0; eb[k] = 0;
      for (int b = 0; b < BINS; b++) begin
        cum[b] = (cum[b] + lv[b] > CMAX) ? CMAX : cum[b] + lv[b];
        if (ef[k] == 0 && cum[b] > int'(thrm[b])) begin
          ef[k] = 1; eb[k] = b;
        end
      end
    end
  endtask

  task automatic pulse_start(int n, int maxl, int sh);
    pulse_cnt = N_W'(n); max_level = N_W'(maxl); bin_shift = SH_W'(sh);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_valid(output bit ok);
    ok = 0;
    for (int c = 0; c < 3000; c++) begin
      if (res_valid) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int c = 0; c < 3000; c++) begin
      if (done) begin ok = 1; break; end
      if (res_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic accept();
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
  endtask

  task automatic run(int n, int maxl, int sh, bit stall);
    bit ok;
    model(n, maxl, sh);
    pulse_start(n, maxl, sh);
    for (int k = 1; k <= maxl; k++) begin
      wait_valid(ok);
      chk("R6 beat present", int'(ok), 1);
      if (!ok) return;
      chk("R6 level", int'(res_level), k);
      chk(ef[k] ? "R4 found" : "R5 none", int'(res_found), ef[k]);
      chk(ef[k] ? "R4 lowest bin" : "R5 bin zero", int'(res_bin), eb[k]);
      if (stall && k == 1) begin
        for (int c = 0; c < 4; c++) begin
          @(negedge clk);
          chk("R7 valid held", int'(res_valid), 1);
          chk("R7 bin held", int'(res_bin), eb[k]);
          chk("R7 level held", int'(res_level), k);
        end
      end
      accept();
    end
    wait_done(ok);
    chk("R9 done after last beat", int'(ok), 1);
    @(negedge clk);
    chk("R9 idle", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    load(1, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      run(VEC[v][0], VEC[v][1], VEC[v][2], v == 1);
    end

    // R10: all times equal, bin 0 gets 15 then 14 more; threshold 14
    load(0, 0, 14, 0);
    pulse_start(16, 2, 0);
    wait_valid(ok);
    chk("R10 level1 found", int'(res_found), 1);
    chk("R10 level1 bin", int'(res_bin), 0);
    accept();
    wait_valid(ok);
    chk("R10 level2 saturated found", int'(res_found), 1);
    chk("R10 level2 bin", int'(res_bin), 0);
    accept();
    wait_done(ok);
    @(negedge clk);

    // R3: fresh run of 4 equal times gives cumulative 3 only, below 14
    pulse_start(4, 1, 0);
    wait_valid(ok);
    chk("R3 cleared at start", int'(res_found), 0);
    accept();
    wait_done(ok);
    @(negedge clk);

    // R8: stop at a pending beat
    load(5, 0, 1, 0);
    pulse_start(8, 3, 0);
    wait_valid(ok);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R8 done on stop", int'(done), 1);
    chk("R8 no beat", int'(res_valid), 0);
    @(negedge clk);
    chk("R8 idle", int'(busy), 0);
    ok = 0;
    for (int c = 0; c < 40; c++) begin
      if (res_valid) ok = 1;
      @(negedge clk);
    end
    chk("R8 no beats after stop", int'(ok), 0);

    // R8: stop while counting pairs
    pulse_start(8, 3, 0);
    @(negedge clk);
    stop = 1;
    @(negedge clk);
    stop = 0;
    chk("R8 done mid count", int'(done), 1);

    // R9: too few pulses and zero levels
    @(negedge clk);
    pulse_start(1, 3, 0);
    wait_done(ok);
    chk("R9 single pulse no beat", int'(ok), 1);
    @(negedge clk);
    pulse_start(8, 0, 0);
    wait_done(ok);
    chk("R9 zero levels no beat", int'(ok), 1);
    @(negedge clk);

    // R2: intervals of 20 exceed 16 bins at shift 0, fit at shift 1 in bin 10
    load(20, 0, 0, 0);
    pulse_start(5, 1, 0);
    wait_valid(ok);
    chk("R2 wide interval discarded", int'(res_found), 0);
    accept();
    wait_done(ok);
    @(negedge clk);
    pulse_start(5, 1, 1);
    wait_valid(ok);
    chk("R2 shifted bin", int'(res_bin), 10);
    accept();
    wait_done(ok);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule